// File: doc/BRIEF.md
# Event Stream Special Character Filter

This block sits on the receive side of a serial link, after the character decoder. Each incoming word carries a control/data flag. The block separates the stream into two outputs:

- payload words, which go to an event buffer;
- one-cycle strobes for the special characters.

Pad and null characters are thrown away wherever they appear. This holds even inside an event, and even when the decoder marks a pad word as ready.

The block follows whether the link is inside an event or in the gap between events. Errors are counted separately for each of the two states. Any error found while an event is open also raises a one-cycle request to initialize the system. An error in the gap is only counted. Several end-of-event variants exist, and each one hands a two-bit status code to the event consumer. A start character that arrives inside an open event closes that event as aborted and opens the new one in the same cycle.

All outputs are registered, so each one appears one clock after the word that causes it.

Top module: `esc_filter`

## Requirements
- R1: After reset the block is in the gap state, every strobe is low and both error counts are zero.
- R2: A word with `in_valid` low has no effect on any output or count.
- R3: A control word with code 1 (pad; the code is bits [3:0] of `in_word`) is dropped in either state without ending an event, even though `in_valid` is high.
- R4: A control word with code 0 (null) is dropped in either state.
- R5: In the gap, control code 2 (start) pulses `evt_open` and enters the event state.
- R6: In an event, a clean data word is presented on `pay_data` with a `pay_wr` pulse one clock later. Special characters never cause a `pay_wr`.
- R7: In an event, control codes 8 to 11 (end) pulse `evt_close` with `close_code` equal to bits [1:0] of the code and `close_abort` low, and return the block to the gap.
- R8: In an event, a start character pulses both `evt_close` and `evt_open`, with `close_abort` high and `close_code` equal to 0. The block stays in the event state and counts one in-event error.
- R9: Control codes 3 (busy) and 4 (free) pulse `busy_stb` or `free_stb` in either state and leave the state unchanged.
- R10: In an event, a word with `in_err` high, or a control word with an illegal code (5 to 7 or 12 to 15), is dropped. It adds one to `ev_err_cnt` and pulses `init_req` for one cycle.
- R11: In the gap, the following are each dropped and each add one to `gap_err_cnt`, and `init_req` stays low:
  - a word with `in_err` high;
  - an illegal code;
  - a data word;
  - an end character.
- R12: Both error counts stop at their all-ones value and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word qualifier from the decoder |
| in_ctrl | input | 1 | High for a control character, low for data |
| in_word | input | DATA_W | Data word, or control code in bits [3:0] |
| in_err | input | 1 | Decoder error on this word |
| pay_wr | output | 1 | Payload write strobe |
| pay_data | output | DATA_W | Payload word |
| evt_open | output | 1 | Event start strobe |
| evt_close | output | 1 | Event end strobe |
| close_code | output | 2 | End variant status, valid with `evt_close` |
| close_abort | output | 1 | The event was closed by a new start |
| busy_stb | output | 1 | Busy character strobe |
| free_stb | output | 1 | Free character strobe |
| in_event | output | 1 | High while an event is open |
| init_req | output | 1 | Initialization request, one cycle |
| ev_err_cnt | output | CNT_W | In-event error count |
| gap_err_cnt | output | CNT_W | In-gap error count |

## Verification
The assertions check these rules on every cycle:
- payload writes, initialization requests and event openings occur only in the event state;
- a close without a new opening always lands in the gap;
- the payload, start, busy and free strobes never overlap;
- a saturated counter stays at its all-ones value.

Only the bench's sweeps can show the rest. The bench drives every control code in both states, data words in both states, and decoder errors. It shows which code maps to which strobe, the exact end-variant status, the abort-on-restart case, and the exact count each error adds. It also shows that pad, null and unqualified words leave every output untouched.

// File: rtl/esc_pkg.sv
package esc_pkg;
   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_DATA  = 3'd1,
      K_START = 3'd2,
      K_END   = 3'd3,
      K_BUSY  = 3'd4,
      K_FREE  = 3'd5,
      K_BAD   = 3'd6
   } kind_t;

   localparam logic [3:0] CODE_NULL  = 4'd0;
   localparam logic [3:0] CODE_PAD   = 4'd1;
   localparam logic [3:0] CODE_START = 4'd2;
   localparam logic [3:0] CODE_BUSY  = 4'd3;
   localparam logic [3:0] CODE_FREE  = 4'd4;
   localparam logic [1:0] END_PREFIX = 2'b10;
endpackage

// File: rtl/esc_classify.sv
module esc_classify
   import esc_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              in_valid,
   input  logic              in_ctrl,
   input  logic [DATA_W-1:0] in_word,
   input  logic              in_err,
   output kind_t             kind,
   output logic [1:0]        variant
);
   localparam int CODE_W = 4;

   logic [CODE_W-1:0] code;
   assign code    = in_word[CODE_W-1:0];
   assign variant = code[1:0];

   always_comb begin
      kind = K_NONE;
      if (!in_valid) begin
         kind = K_NONE;
      end else if (in_err) begin
         kind = K_BAD;
      end else if (!in_ctrl) begin
         kind = K_DATA;
      end else if (code[3:2] == END_PREFIX) begin
         kind = K_END;
      end else begin
         case (code)
            CODE_NULL, CODE_PAD: kind = K_NONE;
            CODE_START:          kind = K_START;
            CODE_BUSY:           kind = K_BUSY;
            CODE_FREE:           kind = K_FREE;
            default:             kind = K_BAD;
         endcase
      end
   end
endmodule

// File: rtl/esc_track.sv
module esc_track
   import esc_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  kind_t             kind,
   input  logic [1:0]        variant,
   input  logic [DATA_W-1:0] word,
   output logic              pay_wr,
   output logic [DATA_W-1:0] pay_data,
   output logic              evt_open,
   output logic              evt_close,
   output logic [1:0]        close_code,
   output logic              close_abort,
   output logic              busy_stb,
   output logic              free_stb,
   output logic              in_event,
   output logic              init_req,
   output logic              err_ev,
   output logic              err_gap
);
   always_comb begin
      err_ev  = in_event && (kind == K_BAD || kind == K_START);
      err_gap = !in_event && (kind == K_BAD || kind == K_DATA || kind == K_END);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pay_wr      <= 1'b0;
         pay_data    <= '0;
         evt_open    <= 1'b0;
         evt_close   <= 1'b0;
         close_code  <= 2'd0;
         close_abort <= 1'b0;
         busy_stb    <= 1'b0;
         free_stb    <= 1'b0;
         in_event    <= 1'b0;
         init_req    <= 1'b0;
      end else begin
         pay_wr      <= 1'b0;
         pay_data    <= '0;
         evt_open    <= 1'b0;
         evt_close   <= 1'b0;
         close_code  <= 2'd0;
         close_abort <= 1'b0;
         busy_stb    <= 1'b0;
         free_stb    <= 1'b0;
         init_req    <= 1'b0;
         case (kind)
            K_DATA: if (in_event) begin
               pay_wr   <= 1'b1;
               pay_data <= word;
            end
            K_START: begin
               evt_open <= 1'b1;
               in_event <= 1'b1;
               if (in_event) begin
                  evt_close   <= 1'b1;
                  close_abort <= 1'b1;
                  init_req    <= 1'b1;
               end
            end
            K_END: if (in_event) begin
               evt_close  <= 1'b1;
               close_code <= variant;
               in_event   <= 1'b0;
            end
            K_BUSY: busy_stb <= 1'b1;
            K_FREE: free_stb <= 1'b1;
            K_BAD:  if (in_event) init_req <= 1'b1;
            default: ;
         endcase
      end
   end

   a_r6_pay_in_event: assert property (@(posedge clk) disable iff (!rst_n)
      pay_wr |-> in_event);
   a_r10_init_from_event: assert property (@(posedge clk) disable iff (!rst_n)
      init_req |-> $past(in_event));
   a_r5_open_enters: assert property (@(posedge clk) disable iff (!rst_n)
      evt_open |-> in_event);
   a_r7_close_leaves: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_close && !evt_open) |-> !in_event);
   a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pay_wr, evt_open, busy_stb, free_stb}));
endmodule

// File: rtl/esc_errcnt.sv
module esc_errcnt #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                cnt <= '0;
            else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
         end
         a_r12_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == TOP) |=> (cnt == TOP));
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)   cnt <= '0;
            else if (inc) cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   a_r11_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt) |-> $past(inc));
endmodule

// File: rtl/esc_filter.sv
module esc_filter
   import esc_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_ctrl,
   input  logic [DATA_W-1:0] in_word,
   input  logic              in_err,
   output logic              pay_wr,
   output logic [DATA_W-1:0] pay_data,
   output logic              evt_open,
   output logic              evt_close,
   output logic [1:0]        close_code,
   output logic              close_abort,
   output logic              busy_stb,
   output logic              free_stb,
   output logic              in_event,
   output logic              init_req,
   output logic [CNT_W-1:0]  ev_err_cnt,
   output logic [CNT_W-1:0]  gap_err_cnt
);
   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("esc_filter: DATA_W must hold a 4-bit control code");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("esc_filter: CNT_W must be at least 1");
      end
   endgenerate

   kind_t      kind;
   logic [1:0] variant;
   logic       err_ev;
   logic       err_gap;

   esc_classify #(.DATA_W(DATA_W)) u_cls (
      .in_valid (in_valid),
      .in_ctrl  (in_ctrl),
      .in_word  (in_word),
      .in_err   (in_err),
      .kind     (kind),
      .variant  (variant)
   );

   esc_track #(.DATA_W(DATA_W)) u_trk (
      .clk         (clk),
      .rst_n       (rst_n),
      .kind        (kind),
      .variant     (variant),
      .word        (in_word),
      .pay_wr      (pay_wr),
      .pay_data    (pay_data),
      .evt_open    (evt_open),
      .evt_close   (evt_close),
      .close_code  (close_code),
      .close_abort (close_abort),
      .busy_stb    (busy_stb),
      .free_stb    (free_stb),
      .in_event    (in_event),
      .init_req    (init_req),
      .err_ev      (err_ev),
      .err_gap     (err_gap)
   );

   esc_errcnt #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt_ev (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (err_ev),
      .cnt   (ev_err_cnt)
   );

   esc_errcnt #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (err_gap),
      .cnt   (gap_err_cnt)
   );

   a_r11_gap_no_init: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_event && !evt_open) |=> !init_req);
endmodule

// File: tb/sim_esc_filter.sv
module sim_esc_filter;
   localparam int DW = 8;
   localparam int CW = 3;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_ctrl = 1'b0, in_err = 1'b0;
   logic [DW-1:0] in_word = '0;
   logic pay_wr, evt_open, evt_close, close_abort, busy_stb, free_stb, in_event, init_req;
   logic [DW-1:0] pay_data;
   logic [1:0] close_code;
   logic [CW-1:0] ev_err_cnt, gap_err_cnt;

   always #10 clk = ~clk;

   esc_filter #(.DATA_W(DW), .CNT_W(CW), .SATURATE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
      .in_word(in_word), .in_err(in_err), .pay_wr(pay_wr), .pay_data(pay_data),
      .evt_open(evt_open), .evt_close(evt_close), .close_code(close_code),
      .close_abort(close_abort), .busy_stb(busy_stb), .free_stb(free_stb),
      .in_event(in_event), .init_req(init_req), .ev_err_cnt(ev_err_cnt),
      .gap_err_cnt(gap_err_cnt)
   );

   int tests = 0;
   int fails = 0;

   // reference state
   logic m_ev = 1'b0;
   logic [CW-1:0] m_evc = '0, m_gapc = '0;

   function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
      return (c == CMAX) ? c : c + 1'b1;
   endfunction

   task automatic compare(input string tag, input logic [DW-1:0] e_data, input logic e_wr,
                          input logic e_open, input logic e_close, input logic [1:0] e_code,
                          input logic e_abort, input logic e_busy, input logic e_free,
                          input logic e_init);
      logic [DW+2*CW+11:0] act, exp;
      act = {pay_wr, pay_wr ? pay_data : '0, evt_open, evt_close, close_code, close_abort,
             busy_stb, free_stb, in_event, init_req, ev_err_cnt, gap_err_cnt};
      exp = {e_wr, e_data, e_open, e_close, e_code, e_abort,
             e_busy, e_free, m_ev, e_init, m_evc, m_gapc};
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive one word, wait one edge, check at the following falling edge
   task automatic send(input logic v, input logic c, input logic [DW-1:0] w, input logic e);
      logic [DW-1:0] x_data = '0;
      logic x_wr = 0, x_open = 0, x_close = 0, x_abort = 0, x_busy = 0, x_free = 0, x_init = 0;
      logic [1:0] x_code = 2'd0;
      logic [3:0] k = w[3:0];
      string tag = "R2";
      in_valid = v; in_ctrl = c; in_word = w; in_err = e;
      @(negedge clk);
      if (v) begin
         if (e || (c && (k inside {4'd5, 4'd6, 4'd7} || k >= 4'd12))) begin
            if (m_ev) begin tag = "R10"; x_init = 1; m_evc = bump(m_evc); end
            else begin tag = "R11"; m_gapc = bump(m_gapc); end
         end else if (!c) begin
            if (m_ev) begin tag = "R6"; x_wr = 1; x_data = w; end
            else begin tag = "R11"; m_gapc = bump(m_gapc); end
         end else if (k == 4'd0) tag = "R4";
         else if (k == 4'd1) tag = "R3";
         else if (k == 4'd2) begin
            x_open = 1;
            if (m_ev) begin tag = "R8"; x_close = 1; x_abort = 1; x_init = 1; m_evc = bump(m_evc); end
            else tag = "R5";
            m_ev = 1;
         end else if (k == 4'd3) begin tag = "R9"; x_busy = 1; end
         else if (k == 4'd4) begin tag = "R9"; x_free = 1; end
         else begin
            if (m_ev) begin tag = "R7"; x_close = 1; x_code = k[1:0]; m_ev = 0; end
            else begin tag = "R11"; m_gapc = bump(m_gapc); end
         end
      end
      compare(tag, x_data, x_wr, x_open, x_close, x_code, x_abort, x_busy, x_free, x_init);
   endtask

   task automatic to_state(input logic want_ev);
      if (want_ev && !m_ev) send(1, 1, 8'h02, 0);
      if (!want_ev && m_ev) send(1, 1, 8'h08, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      compare("R1", '0, 0, 0, 0, 2'd0, 0, 0, 0, 0);

      // sweep every control code in both states, with and without valid
      for (int s = 0; s < 2; s++) begin
         for (int k = 0; k < 16; k++) begin
            to_state(s[0]);
            send(0, 1, 8'(k), 0);            // R2: unqualified word
            to_state(s[0]);
            send(1, 1, 8'(k) | 8'h50, 0);    // upper bits do not matter
         end
      end
      // data words in both states, pad/null inside an event
      to_state(1);
      for (int d = 0; d < 256; d += 17) begin
         send(1, 0, 8'(d), 0);               // R6
         send(1, 1, 8'h01, 0);               // R3: pad mid-event
         send(1, 1, 8'h00, 0);               // R4: null mid-event
      end
      send(1, 1, 8'h0B, 0);                  // R7: end variant 3
      for (int d = 3; d < 256; d += 51) send(1, 0, 8'(d), 0);   // R11: data in gap
      // decoder errors in both states
      to_state(1);
      send(1, 0, 8'hAA, 1);                  // R10
      send(1, 1, 8'h02, 1);                  // R10: error beats start
      to_state(0);
      send(1, 1, 8'h02, 1);                  // R11
      // R12: drive the gap counter well past all-ones
      for (int i = 0; i < 12; i++) send(1, 1, 8'h0F, 0);
      tests++;
      if (gap_err_cnt !== CMAX) begin
         fails++;
         $display("FAIL R12: actual %0d expected %0d", gap_err_cnt, CMAX);
      end
      to_state(1);
      for (int i = 0; i < 12; i++) send(1, 1, 8'h02, 0);   // R8 repeated restarts
      tests++;
      if (ev_err_cnt !== CMAX) begin
         fails++;
         $display("FAIL R12: actual %0d expected %0d", ev_err_cnt, CMAX);
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule